// File: doc/BRIEF.md
# Dual-Clock FIFO with Registered Empty Flag

This block is an 18-bit first-in first-out buffer that joins two unrelated clock domains. A producer pushes words on the write clock. A consumer pops them on the read clock. Each side has an active-low enable. The producer's back-pressure is the active-low not-full output, and the consumer's is the active-low empty flag. A push is taken only on a write edge that sees `wen_n` low and `full_n` high. A pop is taken only on a read edge that sees `ren_n` low and `ef_n` high. A request made while the matching flag blocks it is dropped, not held, so the requester keeps it asserted until the flag allows it.

The read side keeps an output register. It loads only when a pop is taken, and it holds its value otherwise. An active-low output enable either drives that register onto `rdata` or floats the pins; it has no effect on the queue. The empty flag is one register on the read clock. It is computed from the local read pointer and a write pointer that crosses into the read domain in Gray code through two flops. A word written into an empty buffer therefore reaches the consumer after a fixed, small number of read edges. The word appears on `rdata` only on the edge of the first pop taken after the flag rises.

Three selection inputs are captured while reset is held. Only the standard registered-flag behaviour is built. Any other selection value raises `mode_err` and disables both ports.

Top module: `dcf_std`

## Requirements
- R1: While `rst_n` is low and after its release, both pointers are cleared, `ef_n` is low, the output register is zero (seen on `rdata` with `oe_n` low), and `full_n` is high when the captured selection is a standard one.
- R2: The selection {cfg_first_load, cfg_rd_exp, cfg_wr_exp} is sampled while reset is asserted and held after release. The values 000, 011, 100 and 111 select standard operation and keep `mode_err` low. Any other value drives `mode_err` high, `ef_n` low and `full_n` low, and both ports ignore all requests.
- R3: A write edge with `wen_n` low and `full_n` high stores `wdata`. With `full_n` low the request is ignored: the write pointer does not move and no stored word changes.
- R4: `ef_n` comes from a single read-clock register. It is low whenever nothing is stored. After a word is written into an empty buffer, it rises within five read edges: two synchronizer stages and the flag register, plus up to two edges of clock-alignment slack.
- R5: A read edge with `ren_n` low and `ef_n` high loads the oldest stored word into the output register. Words leave in the order they were written.
- R6: The first word is never shown before a pop is taken. While `ef_n` is high and no pop has occurred, `rdata` keeps its reset value.
- R7: With `ren_n` high or `ef_n` low, the output register holds its value and the read pointer does not move. `ef_n` falls only on the edge after a taken pop.
- R8: `oe_n` high sets `rdata` to high impedance. It changes neither the output register nor the read pointer.
- R9: `full_n` goes low once DEPTH words are stored. DEPTH is a power of two, with 256, 512, 1024 and 4096 supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_first_load | input | 1 | Selection bit 2, sampled during reset |
| cfg_rd_exp | input | 1 | Selection bit 1, sampled during reset |
| cfg_wr_exp | input | 1 | Selection bit 0, sampled during reset |
| mode_err | output | 1 | High when the captured selection is not a standard one |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Active-low write request |
| wdata | input | 18 | Word to store |
| full_n | output | 1 | Active-low full; low means writes are dropped |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Active-low read request |
| oe_n | input | 1 | Active-low output enable for `rdata` |
| ef_n | output | 1 | Active-low empty flag, registered on `rclk` |
| rdata | output | 18 | Output register, high impedance when `oe_n` is high |

## Verification
The bench fills the buffer with the reader stalled and keeps pushing past DEPTH. A design that let a blocked write move its pointer would show wrong or repeated words when the buffer is drained. It holds reads off while the flag is already high. A design that pre-loaded the output register would change `rdata` before any pop. It runs a fast reader against a sparse writer so that pops keep hitting the empty boundary. A flag that lags too long, or that rises before the word is stored, shows up as a latency overrun or as wrong data. Resets with each of the four standard selections and with illegal ones check that a bad selection disables both ports, and a toggled `oe_n` during traffic shows that the float control never moves the queue.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W = 18;
  localparam int SEL_W  = 3;

  // selection order {first_load, rd_exp, wr_exp}; standard when the two
  // expansion bits agree
  function automatic logic std_mode(input logic [SEL_W-1:0] sel);
    case (sel)
      3'b000, 3'b011, 3'b100, 3'b111: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             wen_n,
  input  logic [PW-1:0]    rgray_s,
  output logic [PW-1:0]    wgray,
  output logic [AW-1:0]    waddr,
  output logic             we,
  output logic             full_n
);
  logic          mode_ok_q;
  logic [PW-1:0] wbin_q, wbin_nxt;
  logic [PW-1:0] wgray_q;
  logic          full;

  // selection captured only while reset holds this domain
  always_ff @(posedge wclk) begin
    if (!wrst_n) mode_ok_q <= std_mode(sel);
  end

  // full: write pointer one lap ahead of the synchronized read pointer
  assign full   = (wgray_q == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
  assign full_n = mode_ok_q && !full;
  assign we     = !wen_n && full_n;

  assign wbin_nxt = wbin_q + PW'(we);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign wgray = wgray_q;
  assign waddr = wbin_q[AW-1:0];
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             ren_n,
  input  logic [PW-1:0]    wgray_s,
  output logic [PW-1:0]    rgray,
  output logic [AW-1:0]    raddr,
  output logic             re,
  output logic             ef_n,
  output logic             mode_err
);
  logic          mode_ok_q;
  logic [PW-1:0] rbin_q, rbin_nxt, rgray_nxt;
  logic [PW-1:0] rgray_q;
  logic          ef_n_q;

  always_ff @(posedge rclk) begin
    if (!rrst_n) mode_ok_q <= std_mode(sel);
  end

  assign re        = !ren_n && ef_n_q && mode_ok_q;
  assign rbin_nxt  = rbin_q + PW'(re);
  assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);

  // the one register stage behind the empty flag
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      ef_n_q  <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rgray_nxt;
      ef_n_q  <= mode_ok_q && (rgray_nxt != wgray_s);
    end
  end

  assign rgray    = rgray_q;
  assign raddr    = rbin_q[AW-1:0];
  assign ef_n     = ef_n_q;
  assign mode_err = !mode_ok_q;
endmodule

// File: rtl/dcf_std.sv
module dcf_std
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic              rst_n,
  input  logic              cfg_first_load,
  input  logic              cfg_rd_exp,
  input  logic              cfg_wr_exp,
  output logic              mode_err,
  input  logic              wclk,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              full_n,
  input  logic              rclk,
  input  logic              ren_n,
  input  logic              oe_n,
  output logic              ef_n,
  output logic [DATA_W-1:0] rdata
);
  logic [SEL_W-1:0]  sel;
  logic              wrst_n, rrst_n;
  logic [PW-1:0]     wptr_g, rptr_g, wptr_g_s, rptr_g_s;
  logic [AW-1:0]     waddr, raddr;
  logic              we, re;
  logic [DATA_W-1:0] mem_rd, q_q;

  assign sel = {cfg_first_load, cfg_rd_exp, cfg_wr_exp};

  dcf_rst_sync u_wrst (.clk(wclk), .rst_n(rst_n), .rst_sync_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rclk), .rst_n(rst_n), .rst_sync_n(rrst_n));

  dcf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .sel(sel), .wen_n(wen_n),
    .rgray_s(rptr_g_s), .wgray(wptr_g), .waddr(waddr), .we(we),
    .full_n(full_n)
  );

  dcf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .sel(sel), .ren_n(ren_n),
    .wgray_s(wptr_g_s), .rgray(rptr_g), .raddr(raddr), .re(re),
    .ef_n(ef_n), .mode_err(mode_err)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wptr_g), .q(wptr_g_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rptr_g), .q(rptr_g_s));

  dcf_mem #(.DEPTH(DEPTH), .W(DATA_W)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(mem_rd)
  );

  // output register loads only on a taken pop
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  q_q <= '0;
    else if (re)  q_q <= mem_rd;
  end

  assign rdata = oe_n ? 'z : q_q;
endmodule

// File: rtl/dcf_std_chk.sv
module dcf_std_chk #(
  parameter int PW = 9
) (
  input logic          rclk,
  input logic          wclk,
  input logic          rrst_n,
  input logic          wrst_n,
  input logic          ren_n,
  input logic          wen_n,
  input logic          ef_n,
  input logic          full_n,
  input logic          mode_err,
  input logic [17:0]   q_q,
  input logic [PW-1:0] wptr_g,
  input logic [PW-1:0] rptr_g
);
  // R7
  hold_no_read_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    ren_n |=> $stable(q_q));
  // R7
  hold_when_empty_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !ef_n |=> $stable(q_q));
  // R7
  ef_fall_after_read_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $fell(ef_n) |-> $past(!ren_n));
  // R2
  mode_err_empty_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    mode_err |-> !ef_n);
  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!full_n && !wen_n) |=> $stable(wptr_g));
  // R3
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wptr_g ^ $past(wptr_g)) <= 1);
  // R7
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rptr_g ^ $past(rptr_g)) <= 1);
endmodule

bind dcf_std dcf_std_chk #(.PW(PW)) chk_i (
  .rclk(rclk), .wclk(wclk), .rrst_n(rrst_n), .wrst_n(wrst_n),
  .ren_n(ren_n), .wen_n(wen_n), .ef_n(ef_n), .full_n(full_n),
  .mode_err(mode_err), .q_q(q_q), .wptr_g(wptr_g), .rptr_g(rptr_g)
);

// File: tb/dcf_std_tb_top.sv
module dcf_std_tb_top;
  localparam int DEPTH = 256;

  logic        wclk = 1'b0, rclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg = 3'b000;
  logic        wen_n = 1'b1, ren_n = 1'b1, oe_n = 1'b0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        full_n, ef_n, mode_err;

  always #4 wclk = ~wclk;
  initial begin
    #3;
    forever #4 rclk = ~rclk;
  end

  dcf_std #(.DEPTH(DEPTH)) dut_i (
    .rst_n(rst_n), .cfg_first_load(cfg[2]), .cfg_rd_exp(cfg[1]),
    .cfg_wr_exp(cfg[0]), .mode_err(mode_err), .wclk(wclk), .wen_n(wen_n),
    .wdata(wdata), .full_n(full_n), .rclk(rclk), .ren_n(ren_n),
    .oe_n(oe_n), .ef_n(ef_n), .rdata(rdata)
  );

  int          vecs = 0, errs = 0;
  logic [17:0] mq[$];
  logic [17:0] exp_q;
  bit          no_reads;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic bit is_std(input logic [2:0] s);
    return s[1] == s[0];
  endfunction

  task automatic wr_loop(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      bit go;
      @(negedge wclk);
      // R9 / R3: with no pops, DEPTH stored words must hold full_n low
      if (no_reads && mq.size() >= DEPTH)
        chk(full_n == 1'b0, "R9", "full_n with DEPTH words", full_n, 0);
      go    = ($urandom % 100) < pct;
      wdata = 18'($urandom);
      wen_n = !go;
      if (go && full_n) mq.push_back(wdata);
    end
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic rd_loop(input int delay, input int n, input int pct,
                         input bit oe_tog);
    bit pend = 0, seen = 0, used_oe = 0;
    int lat = 0;
    for (int i = 0; i < delay + n + 1; i++) begin
      bit go;
      string tag;
      @(negedge rclk);
      if (pend) begin
        exp_q = mq.pop_front();
        seen  = 1;
      end
      if (pend)               tag = used_oe ? "R8" : "R5";
      else if (ef_n && !seen) tag = "R6";
      else                    tag = "R7";
      if (!oe_n) chk(rdata == exp_q, tag, "rdata", rdata, exp_q);
      if (mq.size() == 0) chk(ef_n == 1'b0, "R4", "ef_n with nothing stored", ef_n, 0);
      if (mq.size() > 0 && !ef_n) lat++;
      else                        lat = 0;
      chk(lat <= 5, "R4", "empty-flag latency", lat, 5);
      no_reads = (i + 1 < delay);
      go = (i >= delay) && (i < delay + n) && (($urandom % 100) < pct);
      if (oe_tog) begin
        oe_n = (($urandom % 4) == 0);
        if (oe_n) used_oe = 1;
      end
      ren_n = !go;
      pend  = go && ef_n;
    end
    ren_n = 1'b1;
    oe_n  = 1'b0;
    @(negedge rclk);
    if (is_std(cfg)) chk(mq.size() == 0, "R5", "words left after drain", mq.size(), 0);
  endtask

  task automatic run_phase(input logic [2:0] sel, input int wn, input int wpct,
                           input int rdelay, input int rn, input int rpct,
                           input bit oe_tog);
    wen_n = 1'b1; ren_n = 1'b1; oe_n = 1'b0;
    cfg   = sel;
    rst_n = 1'b0;
    repeat (5) @(posedge wclk);
    rst_n = 1'b1;
    repeat (4) @(negedge rclk);
    mq.delete();
    exp_q = '0;
    // R1 reset state; R2 selection capture
    chk(ef_n == 1'b0, "R1", "ef_n after reset", ef_n, 0);
    chk(rdata == 18'h0, "R1", "rdata after reset", rdata, 0);
    chk(mode_err == !is_std(sel), "R2", "mode_err", mode_err, !is_std(sel));
    chk(full_n == is_std(sel), "R2", "full_n after reset", full_n, is_std(sel));
    no_reads = (rdelay > 0);
    fork
      wr_loop(wn, wpct);
      rd_loop(rdelay, rn, rpct, oe_tog);
    join
    // R2: selection stays captured after release
    chk(mode_err == !is_std(sel), "R2", "mode_err held", mode_err, !is_std(sel));
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    run_phase(3'b000, 300, 100, 320, 700, 100, 0);  // fill past full, then drain
    run_phase(3'b011, 600,  50,   0, 900,  60, 0);  // mixed traffic
    run_phase(3'b100, 400,  20,   0, 600, 100, 0);  // reader at empty boundary
    run_phase(3'b111, 500,  70,  50, 900,  50, 1);  // output enable toggling
    run_phase(3'b001, 100, 100,   0, 120, 100, 0);  // illegal selection
    run_phase(3'b110, 100, 100,   0, 120, 100, 0);  // illegal selection
    run_phase(3'b000, 100,  50,   0, 300,  50, 0);  // recovery
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule